// File: doc/BRIEF.md
# Framed Serial Register Write Port

This block is the device-side receiver of a three-wire serial write path. An external master supplies a slow serial clock, an active-low frame strobe, a target-select line and serial data. The block runs on a fast system clock and brings all four inputs through two-flop synchronizers. It then finds the serial clock's rising edges in the system domain and shifts in one data bit per edge while the frame strobe is low. Bits arrive most significant first.

A word is always exactly 24 bits long. The master may raise the frame strobe partway through a word to pause it. While paused, the block keeps its bit position and ignores any serial clock edges. Once the strobe falls again, the next captured bit continues the same word. When the 24th bit arrives, the block copies the whole word in one step into one of two 24-bit registers: the control register or the calibration register. The select line, sampled with that last bit, picks the register. In the same cycle the block raises a one-cycle write pulse and a flag that names the register written.

Top module: `sreg_write_port`

## Requirements
- R1: A word is 24 bits. The first bit captured lands in bit 23 of the target register and the 24th bit lands in bit 0.
- R2: Select low (0) writes the control register and select high (1) writes the calibration register. The register that was not selected keeps its value.
- R3: The select line is sampled on the serial clock rising edge that captures the 24th bit. Its value on earlier bits of the word does not choose the target.
- R4: Raising the frame strobe partway through a word pauses the word without losing the bit position. After the strobe falls again, the next bit continues the same word.
- R5: Serial clock rising edges while the frame strobe is high capture nothing, write nothing and do not advance the bit position.
- R6: Each completed word raises the write pulse for exactly one system clock cycle. In that same cycle the flag reads 0 for a control write and 1 for a calibration write. The flag holds its value until the next write.
- R7: A word with fewer than 24 captured bits is never committed. No pulse occurs and both registers keep their values.
- R8: Reset clears both registers, the write pulse, the flag and the bit position. A partial word in progress when reset arrives is discarded.
- R9: The bit position returns to zero after the 24th bit. A second word sent with the frame strobe held low is received whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk_i | input | 1 | Serial clock from the master, idles low |
| frame_n_i | input | 1 | Active-low frame strobe; high pauses the word |
| sel_i | input | 1 | Target select: 0 control, 1 calibration |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| ctrl_reg_o | output | 24 | Control register contents |
| cal_reg_o | output | 24 | Calibration register contents |
| wr_pulse_o | output | 1 | One-cycle pulse when a word is committed |
| wr_is_cal_o | output | 1 | Target of the last write: 0 control, 1 calibration |

## Verification
If the bit counter is off by one, the fault shows as a shifted or rotated value in the target register. It appears within a few system cycles of the last serial clock edge of the word, and no pulse arrives where one is expected. If the counter moves during a pause, the bits after the resume land one place too far, so a word with a distinct pattern on each side of the pause exposes the fault as soon as that word commits. If the select is routed wrongly or sampled at the wrong time, the value appears in the other register and the flag is wrong in the pulse cycle. If the commit fires early, a pulse appears after only 23 bits.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int WORD_W  = 24;
  localparam int NUM_TGT = 2;

  typedef enum logic {
    TGT_CTRL = 1'b0,
    TGT_CAL  = 1'b1
  } tgt_e;
endpackage

// File: rtl/sreg_rst_sync.sv
module sreg_rst_sync (
  input  logic clk,
  input  logic arst_n_i,
  output logic srst_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n_i) begin
    if (!arst_n_i) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n_o = stage_q[1];
endmodule

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int              WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sreg_edge.sv
module sreg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
    end
  end

  assign rise_o = lvl_i & ~prev_q;

  // R5: one rising edge of the serial clock gives one detection only
  a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter #(
  parameter int WORD_W = 24,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              frame_n_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-2:0] sh_q, sh_d;
  logic              shift_en;
  logic              at_last;

  assign shift_en = rise_i & ~frame_n_i;
  assign at_last  = (cnt_q == LAST_IDX);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (shift_en) begin
      sh_d  = {sh_q[WORD_W-3:0], bit_i};
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign done_o = shift_en & at_last;
  assign word_o = {sh_q, bit_i};

  // R1: bit position never leaves the word
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX);

  // R4: a paused frame keeps its bit position
  a_r4_hold_paused: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_i |=> $stable(cnt_q));

  // R9: position wraps to zero after the last bit
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (cnt_q == '0));
endmodule

// File: rtl/sreg_commit.sv
module sreg_commit #(
  parameter int WORD_W  = 24,
  parameter int NUM_TGT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sel_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] cal_o,
  output logic              pulse_o,
  output logic              is_cal_o
);
  import sreg_pkg::*;

  logic [WORD_W-1:0] reg_q [NUM_TGT];
  logic              pulse_q, pulse_d;
  logic              flag_q, flag_d;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    logic              wr_en;
    logic [WORD_W-1:0] nxt;

    assign wr_en = done_i & (sel_i == g[0]);

    always_comb begin
      nxt = reg_q[g];
      if (wr_en) begin
        nxt = word_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= '0;
      end else begin
        reg_q[g] <= nxt;
      end
    end
  end

  always_comb begin
    pulse_d = done_i;
    flag_d  = flag_q;
    if (done_i) begin
      flag_d = sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
    end
  end

  assign ctrl_o   = reg_q[TGT_CTRL];
  assign cal_o    = reg_q[TGT_CAL];
  assign pulse_o  = pulse_q;
  assign is_cal_o = flag_q;

  // R6: write pulse lasts one cycle
  a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R7: registers move only when a full word completes
  a_r7_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_o |-> ($stable(ctrl_o) && $stable(cal_o)));

  // R2: the unselected register is untouched in a write cycle
  a_r2_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !is_cal_o) |-> $stable(cal_o));
  a_r2_cal_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && is_cal_o) |-> $stable(ctrl_o));
endmodule

// File: rtl/sreg_write_port.sv
module sreg_write_port #(
  parameter int WORD_W = sreg_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              frame_n_i,
  input  logic              sel_i,
  input  logic              ser_dat_i,
  output logic [WORD_W-1:0] ctrl_reg_o,
  output logic [WORD_W-1:0] cal_reg_o,
  output logic              wr_pulse_o,
  output logic              wr_is_cal_o
);
  localparam int SYNC_W = 4;
  localparam logic [SYNC_W-1:0] SYNC_RST = 4'b0100;

  logic              srst_n;
  logic [SYNC_W-1:0] raw_in, sync_out;
  logic              sclk_s, frame_s, sel_s, dat_s;
  logic              rise;
  logic              done;
  logic [WORD_W-1:0] word;

  assign raw_in = {ser_clk_i, frame_n_i, sel_i, ser_dat_i};

  sreg_rst_sync u_rst (
    .clk      (clk),
    .arst_n_i (rst_n),
    .srst_n_o (srst_n)
  );

  sreg_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign {sclk_s, frame_s, sel_s, dat_s} = sync_out;

  sreg_edge u_edge (
    .clk    (clk),
    .rst_n  (srst_n),
    .lvl_i  (sclk_s),
    .rise_o (rise)
  );

  sreg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (srst_n),
    .rise_i    (rise),
    .frame_n_i (frame_s),
    .bit_i     (dat_s),
    .done_o    (done),
    .word_o    (word)
  );

  sreg_commit #(.WORD_W(WORD_W), .NUM_TGT(sreg_pkg::NUM_TGT)) u_commit (
    .clk      (clk),
    .rst_n    (srst_n),
    .done_i   (done),
    .word_i   (word),
    .sel_i    (sel_s),
    .ctrl_o   (ctrl_reg_o),
    .cal_o    (cal_reg_o),
    .pulse_o  (wr_pulse_o),
    .is_cal_o (wr_is_cal_o)
  );

  // R8: reset leaves both registers cleared
  a_r8_reset_clear: assert property (@(posedge clk)
    !srst_n |=> (ctrl_reg_o == '0 && cal_reg_o == '0 && !wr_pulse_o));
endmodule

// File: tb/sreg_write_port_tb.sv
module sreg_write_port_tb_top;
  localparam int W    = 24;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ser_clk, frame_n, sel, dat;
  logic [W-1:0] ctrl_reg, cal_reg;
  logic wr_pulse, wr_is_cal;

  int errors = 0;
  int checks = 0;
  int pulse_cnt = 0;
  int wide_pulse = 0;
  logic last_flag = 1'b0;
  logic prev_pulse = 1'b0;
  int cycles = 0;

  always #5 clk = ~clk;

  sreg_write_port dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk_i   (ser_clk),
    .frame_n_i   (frame_n),
    .sel_i       (sel),
    .ser_dat_i   (dat),
    .ctrl_reg_o  (ctrl_reg),
    .cal_reg_o   (cal_reg),
    .wr_pulse_o  (wr_pulse),
    .wr_is_cal_o (wr_is_cal)
  );

  always @(posedge clk) begin
    if (wr_pulse) begin
      pulse_cnt <= pulse_cnt + 1;
      last_flag <= wr_is_cal;
      if (prev_pulse) wide_pulse <= wide_pulse + 1;
    end
    prev_pulse <= wr_pulse;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    @(negedge clk);
    dat = b;
    wait_clk(HALF);
    ser_clk = 1'b1;
    wait_clk(HALF);
    ser_clk = 1'b0;
    wait_clk(HALF);
  endtask

  // Sends the top nbits of data; optional pause after pause_at bits with stray clocks.
  task automatic send(input logic [W-1:0] data, input int nbits,
                      input logic sel_early, input logic sel_last,
                      input int pause_at, input int stray, input bit keep_frame);
    int p0;
    @(negedge clk);
    frame_n = 1'b0;
    wait_clk(2);
    for (int k = 0; k < nbits; k++) begin
      if (k == pause_at) begin
        frame_n = 1'b1;
        wait_clk(HALF);
        p0 = pulse_cnt;
        for (int s = 0; s < stray; s++) clk_bit(s[0]);
        wait_clk(HALF);
        if (stray > 0) chk("R5 stray edges commit nothing", pulse_cnt, p0);
        frame_n = 1'b0;
        wait_clk(2);
      end
      sel = (k == W - 1) ? sel_last : sel_early;
      clk_bit(data[W-1-k]);
    end
    wait_clk(HALF);
    if (!keep_frame) frame_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic t_reset_state();
    chk("R8 ctrl after reset", ctrl_reg, 0);
    chk("R8 cal after reset", cal_reg, 0);
    chk("R8 pulse after reset", wr_pulse, 0);
    chk("R8 flag after reset", wr_is_cal, 0);
  endtask

  task automatic t_ctrl_write();
    int p0 = pulse_cnt;
    send(24'hA5C31E, W, 1'b0, 1'b0, -1, 0, 1'b0);
    chk("R1 ctrl word", ctrl_reg, 24'hA5C31E);
    chk("R2 cal untouched", cal_reg, 0);
    chk("R6 one pulse", pulse_cnt - p0, 1);
    chk("R6 flag control", last_flag, 0);
  endtask

  task automatic t_cal_write();
    int p0 = pulse_cnt;
    send(24'h800001, W, 1'b1, 1'b1, -1, 0, 1'b0);
    chk("R1 msb/lsb in cal", cal_reg, 24'h800001);
    chk("R2 ctrl untouched", ctrl_reg, 24'hA5C31E);
    chk("R6 flag calibration", last_flag, 1);
    chk("R6 flag held", wr_is_cal, 1);
    chk("R6 one pulse", pulse_cnt - p0, 1);
  endtask

  task automatic t_pause();
    send(24'h3C5AF0, W, 1'b0, 1'b0, 11, 3, 1'b0);
    chk("R4 paused word intact", ctrl_reg, 24'h3C5AF0);
    chk("R5 cal untouched by stray", cal_reg, 24'h800001);
    send(24'h0F0F0F, W, 1'b1, 1'b1, 1, 5, 1'b0);
    chk("R4 early pause word", cal_reg, 24'h0F0F0F);
  endtask

  task automatic t_late_select();
    send(24'h135799, W, 1'b0, 1'b1, -1, 0, 1'b0);
    chk("R3 select at last bit picks cal", cal_reg, 24'h135799);
    chk("R3 ctrl unchanged", ctrl_reg, 24'h3C5AF0);
    send(24'h2468AC, W, 1'b1, 1'b0, -1, 0, 1'b0);
    chk("R3 select at last bit picks ctrl", ctrl_reg, 24'h2468AC);
    chk("R3 cal unchanged", cal_reg, 24'h135799);
  endtask

  task automatic t_partial_then_reset();
    int p0 = pulse_cnt;
    send(24'hFFFFFF, W - 1, 1'b0, 1'b0, -1, 0, 1'b0);
    chk("R7 no pulse after 23 bits", pulse_cnt, p0);
    chk("R7 ctrl unchanged", ctrl_reg, 24'h2468AC);
    do_reset();
    chk("R8 ctrl cleared", ctrl_reg, 0);
    chk("R8 cal cleared", cal_reg, 0);
    send(24'h123456, W, 1'b1, 1'b1, -1, 0, 1'b0);
    chk("R8 partial word discarded", cal_reg, 24'h123456);
  endtask

  task automatic t_back_to_back();
    int p0 = pulse_cnt;
    send(24'hFFFFFE, W, 1'b0, 1'b0, -1, 0, 1'b1);
    chk("R9 first word", ctrl_reg, 24'hFFFFFE);
    send(24'h000001, W, 1'b0, 1'b0, -1, 0, 1'b0);
    chk("R9 second word", ctrl_reg, 24'h000001);
    chk("R9 two pulses", pulse_cnt - p0, 2);
  endtask

  initial begin
    rst_n = 1'b0;
    ser_clk = 1'b0;
    frame_n = 1'b1;
    sel = 1'b0;
    dat = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset_state();
    t_ctrl_write();
    t_cal_write();
    t_pause();
    t_late_select();
    t_partial_then_reset();
    t_back_to_back();
    chk("R6 no pulse longer than one cycle", wide_pulse, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule